// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog

This block is a free-running watchdog counter driven by the low-speed 32.768 kHz tick. It starts counting as soon as reset is released, and software cannot turn it off. Software keeps the system alive by writing a two-byte service key. A valid service clears the count, clears any pending warning and loads the timeout period that software has selected.

If one full period passes with no service, the block sends a one-cycle non-maskable interrupt request. This gives software one more period to recover. If a second full period passes with still no service, the block raises a system reset request. That request stays high until the external asynchronous reset is applied.

Periods are powers of two. With the default parameters, the four select codes give 4096, 16384, 65536 and 262144 ticks. At the 32.768 kHz tick these are 125 ms, 500 ms, 2 s and 8 s.

Top module: `escalating_watchdog`

## Requirements
- R1: While reset is applied and right after it, nmiPulse and resetReq are 0. Until the first valid service, the period in force is that of code 0, whatever the value of periodSel.
- R2: The count advances by one every clock from reset release or from a service. If no service happens, the first overflow comes P clocks after that start point and produces an NMI. Here P = 2^(BASE_SHIFT + STEP_SHIFT*code).
- R3: nmiPulse is high for exactly one clock per warning.
- R4: The second overflow in a row with no service between raises resetReq, 2P clocks after the start point. resetReq then stays high until rstN goes low.
- R5: A service is a write of 8'h5A followed by a write of 8'hA5. Idle clocks between the two writes are allowed. A service restarts the count, so the next NMI comes P clocks after the clock that accepts the 8'hA5 write.
- R6: The sequence is broken by any written value other than 8'h5A or 8'hA5 that falls between the two key bytes. After such a break, the 8'hA5 does nothing. A repeated 8'h5A leaves the sequence armed.
- R7: A write of 8'hA5 that does not follow an 8'h5A is ignored.
- R8: A service loads the periodSel code into the period in force. Changing periodSel at any other time does not alter the running interval.
- R9: A service after an NMI and before the second overflow re-arms the first stage. The next overflow then raises another NMI and not a reset.
- R10: Once resetReq is high, services are ignored and no further NMI is produced.
- R11: When a service lands on the same clock as an overflow, the service wins and no NMI is produced for that overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Low-speed tick clock |
| rstN | input | 1 | Asynchronous reset, active low |
| periodSel | input | 2 | Timeout code that the next service loads |
| wrEn | input | 1 | Write strobe for the service key |
| wrData | input | 8 | Service key byte |
| nmiPulse | output | 1 | One-cycle non-maskable interrupt request |
| resetReq | output | 1 | Sticky system reset request |

## Verification
The hardest case to reach from the ports is a service that lands on the same clock as an overflow. The bench derives the overflow clock from its own reset-relative cycle count. It then places the two key writes so that the 8'hA5 is sampled on exactly that edge. The real periods run to hundreds of thousands of clocks, so the bench shrinks them through the BASE_SHIFT and STEP_SHIFT parameters. This lets it walk all four codes, including the full NMI-then-reset escalation for each one.

// File: rtl/wdt_esc_pkg.sv
package wdt_esc_pkg;
  localparam logic [7:0] KEY_ARM  = 8'h5A;
  localparam logic [7:0] KEY_FIRE = 8'hA5;
  localparam int NUM_PERIODS = 4;

  typedef enum logic [1:0] {
    STG_CLEAN   = 2'd0,
    STG_WARNED  = 2'd1,
    STG_EXPIRED = 2'd2
  } wdtStage_e;

  typedef struct packed {
    logic restart;
    logic reloadSel;
  } wdtStrobes_t;
endpackage

// File: rtl/wdt_esc_datapath.sv
module wdt_esc_datapath
  import wdt_esc_pkg::*;
#(
  parameter int BASE_SHIFT = 12,
  parameter int STEP_SHIFT = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  wdtStrobes_t strobes,
  input  logic [1:0]  periodSel,
  output logic        overflowHit
);
  localparam int CNT_W = BASE_SHIFT + STEP_SHIFT * (NUM_PERIODS - 1);

  logic [1:0]                        activeSel;
  logic [CNT_W-1:0]                  count;
  logic [NUM_PERIODS-1:0][CNT_W-1:0] lastValue;

  for (genvar g = 0; g < NUM_PERIODS; g++) begin : gen_limit
    assign lastValue[g] = CNT_W'((64'd1 << (BASE_SHIFT + STEP_SHIFT * g)) - 64'd1);
  end

  assign overflowHit = (count == lastValue[activeSel]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobes.restart || overflowHit) begin
      count <= '0;
    end else begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeSel <= 2'd0;
    end else if (strobes.reloadSel) begin
      activeSel <= periodSel;
    end
  end
endmodule

// File: rtl/wdt_esc_ctrl.sv
module wdt_esc_ctrl
  import wdt_esc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  input  logic        overflowHit,
  output wdtStrobes_t strobes,
  output logic        nmiPulse,
  output logic        resetReq
);
  logic      keyArmed;
  logic      serviceReq;
  logic      serviceOk;
  wdtStage_e stage;

  assign serviceReq = wrEn && keyArmed && (wrData == KEY_FIRE);
  assign serviceOk  = serviceReq && (stage != STG_EXPIRED);

  assign strobes.restart   = serviceOk;
  assign strobes.reloadSel = serviceOk;
  assign resetReq          = (stage == STG_EXPIRED);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyArmed <= 1'b0;
    end else if (wrEn) begin
      keyArmed <= (wrData == KEY_ARM);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage    <= STG_CLEAN;
      nmiPulse <= 1'b0;
    end else begin
      nmiPulse <= 1'b0;
      if (serviceOk) begin
        stage <= STG_CLEAN;
      end else if (overflowHit) begin
        case (stage)
          STG_CLEAN: begin
            stage    <= STG_WARNED;
            nmiPulse <= 1'b1;
          end
          STG_WARNED: stage <= STG_EXPIRED;
          default:    stage <= STG_EXPIRED;
        endcase
      end
    end
  end
endmodule

// File: rtl/escalating_watchdog.sv
module escalating_watchdog
  import wdt_esc_pkg::*;
#(
  parameter int BASE_SHIFT = 12,
  parameter int STEP_SHIFT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] periodSel,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic       nmiPulse,
  output logic       resetReq
);
  wdtStrobes_t strobes;
  logic        overflowHit;

  wdt_esc_datapath #(
    .BASE_SHIFT(BASE_SHIFT),
    .STEP_SHIFT(STEP_SHIFT)
  ) datapath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .periodSel  (periodSel),
    .overflowHit(overflowHit)
  );

  wdt_esc_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .overflowHit(overflowHit),
    .strobes    (strobes),
    .nmiPulse   (nmiPulse),
    .resetReq   (resetReq)
  );
endmodule

// File: rtl/escalating_watchdog_chk.sv
module escalating_watchdog_chk (
  input logic clk,
  input logic rstN,
  input logic nmiPulse,
  input logic resetReq,
  input logic overflowHit,
  input logic restart
);
  assert_nmi_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    nmiPulse |=> !nmiPulse);

  assert_nmi_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    nmiPulse |-> ($past(overflowHit) && !$past(restart)));

  assert_reset_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> resetReq);

  assert_reset_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetReq) |-> ($past(overflowHit) && !$past(restart)));

  assert_service_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (!nmiPulse && !resetReq));

  assert_no_nmi_expired_R10: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> !nmiPulse);
endmodule

bind escalating_watchdog escalating_watchdog_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .nmiPulse   (nmiPulse),
  .resetReq   (resetReq),
  .overflowHit(overflowHit),
  .restart    (strobes.restart)
);

// File: tb/escalating_watchdog_tb_top.sv
module escalating_watchdog_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 4;
  localparam int STEP = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] periodSel = 2'd0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       nmiPulse;
  logic       resetReq;

  int cyc;
  int checks = 0;
  int errors = 0;
  bit prevRst = 0;
  bit finished = 0;

  typedef struct {
    int    when;
    bit    isRst;
    string tag;
  } exp_t;
  exp_t sbq[$];

  escalating_watchdog #(.BASE_SHIFT(BASE), .STEP_SHIFT(STEP)) dut_i (
    .clk(clk), .rstN(rstN), .periodSel(periodSel), .wrEn(wrEn),
    .wrData(wrData), .nmiPulse(nmiPulse), .resetReq(resetReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rstN)
    if (!rstN) cyc <= 0; else cyc <= cyc + 1;

  function automatic int periodOf(int code);
    return 1 << (BASE + STEP * code);
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic expect_ev(int when, bit isRst, string tag);
    exp_t e;
    e.when = when; e.isRst = isRst; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic popCheck(bit isRst);
    exp_t e;
    if (sbq.size() == 0) begin
      check(0, isRst ? "unexpected reset R10" : "unexpected nmi R3", cyc, -1);
    end else begin
      e = sbq.pop_front();
      check(e.isRst == isRst && e.when == cyc, e.tag, cyc, e.when);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (nmiPulse) popCheck(1'b0);
      if (resetReq && !prevRst) popCheck(1'b1);
      prevRst = resetReq;
    end else begin
      prevRst = 1'b0;
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check(nmiPulse == 1'b0, "R1 nmi in reset", nmiPulse, 0);
    check(resetReq == 1'b0, "R1 resetReq in reset", resetReq, 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitUntil(int c);
    while (cyc < c) @(negedge clk);
  endtask

  // drive a write that the design samples at edge number "edge"
  task automatic wrAt(int edgeNum, logic [7:0] v);
    while (cyc < edgeNum - 1) @(negedge clk);
    wrEn = 1'b1;
    wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic svc(int edgeNum);
    wrAt(edgeNum - 1, 8'h5A);
    wrAt(edgeNum, 8'hA5);
  endtask

  task automatic endScenario(string tag);
    check(sbq.size() == 0, tag, sbq.size(), 0);
    sbq.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 R2 R4 R10: escalation with no service, then lock-out
    periodSel = 2'd0;
    doReset();
    expect_ev(16, 1'b0, "R2 first nmi");
    expect_ev(32, 1'b1, "R4 reset request");
    waitUntil(40);
    check(resetReq == 1'b1, "R4 sticky", resetReq, 1);
    svc(42);
    waitUntil(150);
    check(resetReq == 1'b1, "R10 service ignored when expired", resetReq, 1);
    endScenario("R10 no extra events");
    doReset();
    check(resetReq == 1'b0, "R1 resetReq cleared by reset", resetReq, 0);

    // R5 R9: service, warning, service re-arms
    svc(10);
    expect_ev(26, 1'b0, "R5 nmi after service");
    waitUntil(28);
    svc(30);
    expect_ev(46, 1'b0, "R9 nmi again after re-arm");
    expect_ev(62, 1'b1, "R9 reset after second miss");
    waitUntil(70);
    endScenario("R9 scenario drained");

    // R6 broken sequence
    doReset();
    wrAt(4, 8'h5A);
    wrAt(5, 8'h33);
    wrAt(6, 8'hA5);
    expect_ev(16, 1'b0, "R6 broken key no service");
    expect_ev(32, 1'b1, "R6 broken key reset");
    waitUntil(40);
    endScenario("R6 scenario drained");

    // R6 repeated arm byte stays armed
    doReset();
    wrAt(4, 8'h5A);
    wrAt(5, 8'h5A);
    wrAt(6, 8'hA5);
    expect_ev(22, 1'b0, "R6 repeated arm services");
    expect_ev(38, 1'b1, "R6 repeated arm reset");
    waitUntil(45);
    endScenario("R6 repeat drained");

    // R7 lone fire byte; R1 default period despite periodSel
    periodSel = 2'd2;
    doReset();
    wrAt(5, 8'hA5);
    expect_ev(16, 1'b0, "R7 lone A5 ignored / R1 default period");
    waitUntil(18);
    svc(20);
    expect_ev(20 + periodOf(2), 1'b0, "R8 code 2 nmi");
    expect_ev(20 + 2 * periodOf(2), 1'b1, "R8 code 2 reset");
    waitUntil(20 + 2 * periodOf(2) + 5);
    endScenario("R7 scenario drained");

    // R8 each code, periodSel changed after service without effect
    for (int code = 0; code < 4; code++) begin
      periodSel = 2'(code);
      doReset();
      svc(5);
      periodSel = 2'((code + 1) % 4);
      expect_ev(5 + periodOf(code), 1'b0, "R8 period nmi");
      expect_ev(5 + 2 * periodOf(code), 1'b1, "R8 period reset");
      waitUntil(5 + 2 * periodOf(code) + 4);
      endScenario("R8 code drained");
    end

    // R11 service on the overflow edge
    periodSel = 2'd0;
    doReset();
    svc(16);
    expect_ev(32, 1'b0, "R11 service beats overflow");
    expect_ev(48, 1'b1, "R11 reset afterwards");
    waitUntil(55);
    endScenario("R11 scenario drained");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule